// File: doc/BRIEF.md
# Instruction-Driven Serial Register Port

This block is a synchronous serial slave that lets a host reach a small byte-addressed register file. The host lowers chip select and shifts in one instruction byte. The instruction byte selects read or write, a byte count of one to four, and a starting byte address. A data phase of that many bytes follows. After the last byte the port returns to waiting for the next instruction. The only way to recover from a host that has lost count is reset.

Two control bits set how multi-byte words move. With both bits clear, the byte address steps down after each byte and bits leave or arrive most significant first. With both bits set, the address steps up and bits travel least significant first. Read data leaves either on the shared data pin or on a separate output pin. The shift clock comes either from an external host or from an internal divider running at one eighth of the system clock.

A 24-bit conversion result is loaded through a parallel strobe. An active-low ready flag falls when a new result arrives. The flag rises only after one read cycle has fully shifted out all three result bytes. All serial inputs are sampled in the system clock domain.

Top module: `ser_reg_port`

## Requirements
- R1: The instruction byte is shifted in most significant bit first, one bit per shift-clock rising edge. Its bit 7 selects read (1) or write (0), bits 6:5 hold the byte count minus one, and bits 2:0 hold the starting byte address. Once the last data byte has moved, the port expects a new instruction.
- R2: When control bits ascend=0 and lsb_first=0, the byte address decrements after each data byte and each byte is shifted most significant bit first.
- R3: The control register is at address 3. Its bit 0 (ascend) makes the address increment after each byte, and its bit 1 (lsb_first) makes bytes shift least significant bit first. Its bits 7:2 read as zero.
- R4: Addresses 0, 1 and 2 hold result bytes from least to most significant; they are read-only, and writes to them change nothing. Addresses 4 to 7 are read/write scratch bytes. Address stepping wraps modulo 8.
- R5: drdy_n is low in the clock cycle after res_load is sampled high.
- R6: drdy_n returns high only at the end of a read cycle in which all three result bytes were fully shifted out. A read that covers only part of the result leaves drdy_n low.
- R7: With three_wire=0, read data appears on sdio_out, sdio_oe is high during the read data phase, and sdo stays low. With three_wire=1, read data appears on sdo and sdio_oe stays low.
- R8: While cs_n is high, shift-clock edges are ignored and a partly transferred byte is held. When cs_n falls again, the transfer continues from the same bit.
- R9: With mode_self=1 and cs_n low, the port drives sclk_out with a period of 8 clk cycles and uses it as the shift clock. With mode_self=0, sclk_out stays low and sclk_in is the shift clock.
- R10: After reset, drdy_n is high, the control register and scratch bytes are zero, and the port waits for an instruction.
- R11: Input data is sampled on the rising shift-clock edge. Read data changes on the falling edge. Each read byte is captured from the register file when its first bit is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the source of the internal shift clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_self | input | 1 | 1: internal divided shift clock, 0: external sclk_in |
| three_wire | input | 1 | 1: read data on sdo, 0: read data on the shared pin |
| cs_n | input | 1 | Active-low chip select |
| sclk_in | input | 1 | External shift clock |
| sdio_in | input | 1 | Serial data into the port (shared pin input side) |
| sdio_out | output | 1 | Serial read data for the shared pin |
| sdio_oe | output | 1 | Output enable for the shared pin |
| sdo | output | 1 | Separate serial read data output |
| sclk_out | output | 1 | Internally generated shift clock |
| res_load | input | 1 | Strobe that loads res_data into the result bytes |
| res_data | input | 24 | New conversion result |
| drdy_n | output | 1 | Active-low new-result flag |

## Verification
A table of write-then-readback cycles is run under all four combinations of the control bits, with byte counts from one to four and both stepping directions. The multi-byte read and the single-byte reads of each touched address must agree. This separates a wrong address step from a wrong bit order. Result reads run once in each of the two main orderings, to tell descending from ascending traversal, and once as a partial read, to show that the ready flag is not released early. Further directed cycles cover writes to read-only bytes, address wrap, chip select dropped in the middle of a byte, and a read clocked by the internal divider, which checks its period.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    localparam int ADDR_W    = 3;
    localparam int NREGS     = 1 << ADDR_W;
    localparam int RES_BYTES = 3;
    localparam int RES_W     = 8 * RES_BYTES;
    localparam int CTRL_ADDR = 3;
    localparam int SCR_BASE  = 4;
    localparam int NSCR      = NREGS - SCR_BASE;
    localparam int CNT_W     = 2;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [CNT_W-1:0]  cnt_m1;
        logic [1:0]        rsvd;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef struct packed {
        logic lsb_first;
        logic ascend;
    } ctrl_t;

    function automatic logic pick_bit(logic [7:0] b, logic [2:0] idx, logic lsb);
        return lsb ? b[idx] : b[3'd7 - idx];
    endfunction

    function automatic logic [7:0] take_bit(logic [7:0] acc, logic d, logic lsb);
        return lsb ? {d, acc[7:1]} : {acc[6:0], d};
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(logic [ADDR_W-1:0] a, logic asc);
        return asc ? a + 1'b1 : a - 1'b1;
    endfunction

endpackage

// File: rtl/ser_clk_ctl.sv
module ser_clk_ctl #(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_self,
    input  logic cs_n,
    input  logic sclk_in,
    input  logic sdio_in,
    output logic active,
    output logic sdi,
    output logic rise_evt,
    output logic fall_evt,
    output logic sclk_out
);
    localparam int DIV_W = $clog2(DIV);
    localparam int HALF  = DIV / 2;

    // bit 2: cs_n, bit 1: sclk, bit 0: data
    logic [2:0] sync_q [SYNC_STAGES];

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 3'b100;
                    else     sync_q[g] <= {cs_n, sclk_in, sdio_in};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 3'b100;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    logic             ext_prev;
    logic [DIV_W-1:0] div_q;
    logic             ext_s;

    assign ext_s  = sync_q[SYNC_STAGES-1][1];
    assign sdi    = sync_q[SYNC_STAGES-1][0];
    assign active = ~sync_q[SYNC_STAGES-1][2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_prev <= 1'b0;
            div_q    <= '0;
        end else begin
            ext_prev <= ext_s;
            if (mode_self && active)
                div_q <= (div_q == DIV_W'(DIV - 1)) ? '0 : div_q + 1'b1;
            else
                div_q <= '0;
        end
    end

    assign sclk_out = (div_q >= DIV_W'(HALF));

    always_comb begin
        if (mode_self) begin
            rise_evt = active && (div_q == DIV_W'(HALF - 1));
            fall_evt = active && (div_q == DIV_W'(DIV - 1));
        end else begin
            rise_evt = active &&  ext_s && !ext_prev;
            fall_evt = active && !ext_s &&  ext_prev;
        end
    end

endmodule

// File: rtl/ser_engine.sv
module ser_engine
    import ser_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              sdi,
    input  ctrl_t             ctrl,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [7:0]        wdata,
    output logic              sd_out,
    output logic              rd_phase,
    output logic [2:0]        bit_cnt,
    output logic              res_read_done
);
    phase_e                 phase_q;
    logic                   rd_q;
    logic [CNT_W-1:0]       left_q;
    logic [7:0]             sh_q;
    logic [7:0]             tx_q;
    logic [RES_BYTES-1:0]   rmask_q;
    logic [RES_BYTES-1:0]   hit;
    logic                   byte_end;
    instr_t                 ins;
    logic                   ins_unused;

    assign ins        = instr_t'({sh_q[6:0], sdi});
    assign ins_unused = ^ins.rsvd;
    assign byte_end   = rise_evt && (bit_cnt == 3'd7);
    assign rd_phase   = (phase_q == PH_DATA) && rd_q;

    always_comb begin
        hit = '0;
        for (int k = 0; k < RES_BYTES; k++)
            if (addr == ADDR_W'(k)) hit[k] = 1'b1;
    end

    assign wdata         = take_bit(sh_q, sdi, ctrl.lsb_first);
    assign we            = byte_end && (phase_q == PH_DATA) && !rd_q;
    assign res_read_done = byte_end && rd_phase && (left_q == '0) &&
                           ((rmask_q | hit) == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_INSTR;
            rd_q    <= 1'b0;
            left_q  <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            rmask_q <= '0;
            addr    <= '0;
            bit_cnt <= '0;
            sd_out  <= 1'b0;
        end else if (rise_evt) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (phase_q == PH_INSTR) begin
                sh_q <= {sh_q[6:0], sdi};
                if (bit_cnt == 3'd7) begin
                    phase_q <= PH_DATA;
                    rd_q    <= ins.rd;
                    left_q  <= ins.cnt_m1;
                    addr    <= ins.addr;
                    rmask_q <= '0;
                end
            end else begin
                sh_q <= wdata;
                if (bit_cnt == 3'd7) begin
                    if (rd_q) rmask_q <= rmask_q | hit;
                    addr <= step_addr(addr, ctrl.ascend);
                    if (left_q == '0) phase_q <= PH_INSTR;
                    else              left_q  <= left_q - 1'b1;
                end
            end
        end else if (fall_evt && rd_phase && active) begin
            if (bit_cnt == 3'd0) begin
                tx_q   <= rdata;
                sd_out <= pick_bit(rdata, 3'd0, ctrl.lsb_first);
            end else begin
                sd_out <= pick_bit(tx_q, bit_cnt, ctrl.lsb_first);
            end
        end
    end

endmodule

// File: rtl/ser_regs.sv
module ser_regs
    import ser_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata,
    input  logic              res_load,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_read_done,
    output ctrl_t             ctrl,
    output logic              drdy_n
);
    logic [7:0] res_q [RES_BYTES];
    logic [7:0] scr_q [NSCR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < RES_BYTES; k++) res_q[k] <= '0;
        end else if (res_load) begin
            for (int k = 0; k < RES_BYTES; k++) res_q[k] <= res_data[8*k +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we && waddr == ADDR_W'(CTRL_ADDR)) begin
            ctrl.lsb_first <= wdata[1];
            ctrl.ascend    <= wdata[0];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NSCR; g++) begin : g_scr
            always_ff @(posedge clk) begin
                if (rst)
                    scr_q[g] <= '0;
                else if (we && waddr == ADDR_W'(SCR_BASE + g))
                    scr_q[g] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                drdy_n <= 1'b1;
        else if (res_load)      drdy_n <= 1'b0;
        else if (res_read_done) drdy_n <= 1'b1;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < RES_BYTES; k++)
            if (raddr == ADDR_W'(k)) rdata = res_q[k];
        if (raddr == ADDR_W'(CTRL_ADDR))
            rdata = {6'b0, ctrl.lsb_first, ctrl.ascend};
        for (int k = 0; k < NSCR; k++)
            if (raddr == ADDR_W'(SCR_BASE + k)) rdata = scr_q[k];
    end

endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
    import ser_port_pkg::*;
#(
    parameter int DIV         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_self,
    input  logic             three_wire,
    input  logic             cs_n,
    input  logic             sclk_in,
    input  logic             sdio_in,
    output logic             sdio_out,
    output logic             sdio_oe,
    output logic             sdo,
    output logic             sclk_out,
    input  logic             res_load,
    input  logic [RES_W-1:0] res_data,
    output logic             drdy_n
);
    logic              active;
    logic              sdi;
    logic              rise_evt;
    logic              fall_evt;
    logic [ADDR_W-1:0] addr;
    logic              we;
    logic [7:0]        wdata;
    logic [7:0]        rdata;
    logic              sd_out;
    logic              rd_phase;
    logic [2:0]        bit_cnt;
    logic              res_read_done;
    ctrl_t             ctrl;

    ser_clk_ctl #(
        .DIV         (DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_clk (
        .clk       (clk),
        .rst       (rst),
        .mode_self (mode_self),
        .cs_n      (cs_n),
        .sclk_in   (sclk_in),
        .sdio_in   (sdio_in),
        .active    (active),
        .sdi       (sdi),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .sclk_out  (sclk_out)
    );

    ser_engine u_eng (
        .clk           (clk),
        .rst           (rst),
        .active        (active),
        .rise_evt      (rise_evt),
        .fall_evt      (fall_evt),
        .sdi           (sdi),
        .ctrl          (ctrl),
        .rdata         (rdata),
        .addr          (addr),
        .we            (we),
        .wdata         (wdata),
        .sd_out        (sd_out),
        .rd_phase      (rd_phase),
        .bit_cnt       (bit_cnt),
        .res_read_done (res_read_done)
    );

    ser_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .we            (we),
        .waddr         (addr),
        .wdata         (wdata),
        .raddr         (addr),
        .rdata         (rdata),
        .res_load      (res_load),
        .res_data      (res_data),
        .res_read_done (res_read_done),
        .ctrl          (ctrl),
        .drdy_n        (drdy_n)
    );

    assign sdio_out = sd_out;
    assign sdio_oe  = rd_phase && active && !three_wire;
    assign sdo      = three_wire && sd_out;

endmodule

// File: rtl/ser_port_chk.sv
module ser_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_self,
    input logic       res_load,
    input logic       drdy_n,
    input logic       res_read_done,
    input logic       active,
    input logic [2:0] bit_cnt,
    input logic       sclk_out
);
    a_r5_drdy_falls_on_load: assert property (@(posedge clk) disable iff (rst)
        res_load |=> !drdy_n);

    a_r6_drdy_rise_needs_full_read: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> $past(res_read_done));

    a_r8_bits_hold_when_deselected: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(bit_cnt));

    a_r9_no_internal_clock_in_external_mode: assert property (@(posedge clk) disable iff (rst)
        !mode_self |=> !sclk_out);
endmodule

bind ser_reg_port ser_port_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_self     (mode_self),
    .res_load      (res_load),
    .drdy_n        (drdy_n),
    .res_read_done (res_read_done),
    .active        (active),
    .bit_cnt       (bit_cnt),
    .sclk_out      (sclk_out)
);

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        mode_self = 1'b0;
    logic        three_wire = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe, sdo, sclk_out, drdy_n;
    logic        res_load = 1'b0;
    logic [23:0] res_data = '0;

    ser_reg_port u0 (
        .clk(clk), .rst(rst), .mode_self(mode_self), .three_wire(three_wire),
        .cs_n(cs_n), .sclk_in(sclk_in), .sdio_in(sdio_in), .sdio_out(sdio_out),
        .sdio_oe(sdio_oe), .sdo(sdo), .sclk_out(sclk_out), .res_load(res_load),
        .res_data(res_data), .drdy_n(drdy_n)
    );

    int checks = 0;
    int fails  = 0;
    logic [1:0] cur_ctrl = 2'b00;   // {lsb_first, ascend}

    typedef struct packed {
        logic [1:0]  ctrl;
        logic [2:0]  start;
        logic [2:0]  n;
        logic [31:0] data;          // byte i at [8*i +: 8], i = transfer order
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 3'd7, 3'd4, 32'h44332211},
        '{2'd3, 3'd4, 3'd4, 32'hF00D5A3C},
        '{2'd0, 3'd6, 3'd2, 32'h00009E71},
        '{2'd3, 3'd5, 3'd1, 32'h000000C8},
        '{2'd1, 3'd5, 3'd3, 32'h00123456},
        '{2'd2, 3'd7, 3'd2, 32'h0000ABCD}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic d, output logic q, output logic oe);
        sclk_in = 1'b0;
        sdio_in = d;
        wait_clk(4);
        q  = three_wire ? sdo : sdio_out;
        oe = sdio_oe;
        sclk_in = 1'b1;
        wait_clk(4);
    endtask

    task automatic byte_x(input logic [7:0] tx, input logic lsb,
                          output logic [7:0] rx, output logic oe_all, output logic oe_any);
        logic q, oe;
        oe_all = 1'b1;
        oe_any = 1'b0;
        rx = '0;
        for (int i = 0; i < 8; i++) begin
            bit_x(lsb ? tx[i] : tx[7-i], q, oe);
            if (lsb) rx[i] = q; else rx[7-i] = q;
            oe_all &= oe;
            oe_any |= oe;
        end
    endtask

    task automatic cyc_begin();
        cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic cyc_end();
        cs_n = 1'b1;
        wait_clk(4);
        sclk_in = 1'b0;
        wait_clk(4);
    endtask

    task automatic xfer(input logic rd, input logic [2:0] addr, input int n,
                        input logic [31:0] wdat, output logic [31:0] rdat,
                        output logic oe_all, output logic oe_any);
        logic [7:0] b;
        logic a, o;
        rdat = '0;
        oe_all = 1'b1;
        oe_any = 1'b0;
        cyc_begin();
        byte_x({rd, 2'(n - 1), 2'b00, addr}, 1'b0, b, a, o);
        for (int i = 0; i < n; i++) begin
            byte_x(wdat[8*i +: 8], cur_ctrl[1], b, a, o);
            rdat[8*i +: 8] = b;
            oe_all &= a;
            oe_any |= o;
        end
        cyc_end();
    endtask

    task automatic wr(input logic [2:0] addr, input int n, input logic [31:0] d);
        logic [31:0] r;
        logic a, o;
        xfer(1'b0, addr, n, d, r, a, o);
    endtask

    task automatic rd(input logic [2:0] addr, input int n, output logic [31:0] d);
        logic a, o;
        xfer(1'b1, addr, n, 32'h0, d, a, o);
    endtask

    task automatic set_ctrl(input logic [1:0] v);
        wr(3'd3, 1, {30'b0, v});
        cur_ctrl = v;
    endtask

    task automatic load_result(input logic [23:0] v);
        res_data = v;
        res_load = 1'b1;
        wait_clk(1);
        res_load = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        oa, oy;
        logic [7:0]  rx, ib;
        logic [2:0]  a;
        logic [31:0] mask;
        string       tag;
        time         t0;

        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        // R10: reset state
        chk("R10", "drdy_n after reset", {31'b0, drdy_n}, 32'd1);
        chk("R10", "sdio_oe after reset", {31'b0, sdio_oe}, 32'd0);
        chk("R9", "sclk_out in external mode", {31'b0, sclk_out}, 32'd0);
        rd(3'd3, 1, d);
        chk("R10", "control after reset", d, 32'h0);
        rd(3'd4, 1, d);
        chk("R10", "scratch after reset", d, 32'h0);

        // Table walk: write, multi-byte readback, single-byte readback (R1 R2 R3 R4)
        for (int v = 0; v < 6; v++) begin
            set_ctrl(VECS[v].ctrl);
            tag = (VECS[v].ctrl == 2'd0) ? "R2" : (VECS[v].ctrl == 2'd3) ? "R3" : "R1";
            mask = (VECS[v].n == 3'd4) ? 32'hFFFFFFFF : ((32'h1 << (8 * VECS[v].n)) - 1);
            wr(VECS[v].start, int'(VECS[v].n), VECS[v].data);
            rd(VECS[v].start, int'(VECS[v].n), d);
            chk(tag, $sformatf("vec %0d multi-byte readback", v), d, VECS[v].data & mask);
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                a = VECS[v].ctrl[0] ? VECS[v].start + 3'(i) : VECS[v].start - 3'(i);
                rd(a, 1, d);
                chk("R4", $sformatf("vec %0d byte %0d at addr %0d", v, i, a),
                    d, {24'b0, VECS[v].data[8*i +: 8]});
            end
        end

        // R5 R6 R2 R7: descending MSB-first result read on the shared pin
        set_ctrl(2'd0);
        three_wire = 1'b0;
        load_result(24'h9A5CE1);
        chk("R5", "drdy_n after load", {31'b0, drdy_n}, 32'd0);
        rd(3'd2, 2, d);
        chk("R2", "partial result read", d, 32'h00005C9A);
        chk("R6", "drdy_n after partial read", {31'b0, drdy_n}, 32'd0);
        xfer(1'b1, 3'd2, 3, 32'h0, d, oa, oy);
        chk("R2", "full result read descending", d, 32'h00E15C9A);
        chk("R7", "sdio_oe during 2-wire read", {31'b0, oa}, 32'd1);
        chk("R6", "drdy_n after full read", {31'b0, drdy_n}, 32'd1);

        // R3 R7 R5 R6: ascending LSB-first result read on the separate pin
        set_ctrl(2'd3);
        three_wire = 1'b1;
        load_result(24'h0F1E2D);
        chk("R5", "drdy_n after second load", {31'b0, drdy_n}, 32'd0);
        xfer(1'b1, 3'd0, 3, 32'h0, d, oa, oy);
        chk("R3", "full result read ascending", d, 32'h000F1E2D);
        chk("R7", "sdio_oe during 3-wire read", {31'b0, oy}, 32'd0);
        chk("R6", "drdy_n after ascending read", {31'b0, drdy_n}, 32'd1);

        // R4: result bytes ignore writes; address wraps 7 -> 0
        wr(3'd1, 1, 32'h55);
        rd(3'd1, 1, d);
        chk("R4", "write to result byte ignored", d, 32'h1E);
        wr(3'd7, 1, 32'h6B);
        rd(3'd7, 2, d);
        chk("R4", "ascending wrap 7 to 0", d, 32'h00002D6B);

        // R3: upper control bits read as zero
        wr(3'd3, 1, 32'hFF);
        cur_ctrl = 2'd3;
        rd(3'd3, 1, d);
        chk("R3", "control readback masks bits 7:2", d, 32'h03);

        // R8: chip select dropped mid-byte freezes the transfer
        set_ctrl(2'd0);
        three_wire = 1'b0;
        begin
            logic q, oe;
            ib = 8'hB6;
            cyc_begin();
            byte_x(8'h04, 1'b0, rx, oa, oy);
            for (int i = 7; i >= 4; i--) bit_x(ib[i], q, oe);
            cs_n = 1'b1;
            wait_clk(4);
            sdio_in = 1'b0;
            for (int k = 0; k < 3; k++) begin
                sclk_in = 1'b0; wait_clk(4);
                sclk_in = 1'b1; wait_clk(4);
            end
            sclk_in = 1'b0;
            wait_clk(4);
            cs_n = 1'b0;
            wait_clk(4);
            for (int i = 3; i >= 0; i--) bit_x(ib[i], q, oe);
            cyc_end();
        end
        rd(3'd4, 1, d);
        chk("R8", "byte resumed after deselect", d, 32'hB6);
        chk("R1", "port back in instruction phase", d, 32'hB6);

        // R9 R11: read control register using the internal shift clock
        set_ctrl(2'd1);
        mode_self = 1'b1;
        wait_clk(4);
        chk("R9", "sclk_out idle while deselected", {31'b0, sclk_out}, 32'd0);
        ib = 8'h83;
        rx = '0;
        t0 = 0;
        sdio_in = ib[7];
        cs_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(posedge sclk_out);
            #1;
            if (i == 0) t0 = $time;
            if (i == 1) chk("R9", "internal shift clock period", 32'($time - t0), 32'd80);
            if (i >= 8) rx[15-i] = sdio_out;
            @(negedge sclk_out);
            #1;
            if (i == 15)     cs_n = 1'b1;
            else if (i < 7)  sdio_in = ib[6-i];
            else             sdio_in = 1'b0;
        end
        wait_clk(8);
        chk("R11", "read over internal clock", {24'b0, rx}, 32'h01);
        mode_self = 1'b0;
        wait_clk(4);
        chk("R9", "sclk_out low after leaving internal mode", {31'b0, sclk_out}, 32'd0);

        finish_run();
    end
endmodule